// File: doc/BRIEF.md
# Register-list multiple transfer sequencer

This block turns a single 16-bit multiple-transfer instruction into a run of 32-bit memory accesses, one per cycle. It handles four kinds of transfer: block load and block store against a general base register, and pop and push against the stack pointer. Which of the eight low registers take part is given by an 8-bit bitmap. Pop can also fetch one more word into the program counter, and push can also save the link register.

The surrounding core pulses `start` with the instruction word and the current value of the base or stack pointer. The sequencer then owns the memory port until it finishes. It reads store data through a register-file read port and writes loaded words through a register-file write port. A word destined for the program counter is presented on a separate load output. One cycle after the last accepted access, the sequencer pulses `done`. In that same cycle it hands back the final pointer value and the index of the register that should receive it.

Top module: `regmulti_seq`

## Requirements
- R1: `instr[15:12]`=0xC selects block transfer. In that case `instr[11]`=1 means load, 0 means store, and `instr[10:8]` is the base register index. `instr[15:12]`=0xB together with `instr[10:9]`=2'b10 selects a stack transfer. In that case `instr[11]`=1 means pop, 0 means push, and `instr[8]` is the extra-slot bit. `instr[7:0]` is the register bitmap in both forms. Any other word leaves the block idle, with no access and no `done`.
- R2: Block load and block store visit set bitmap bits from bit 0 upward. Access k uses address base+4k, and the final pointer is base+4n, where n is the number of set bits.
- R3: Pop visits set bits from bit 0 upward at base+4k. With the extra bit, one further read at base+4n is driven onto `pc_value` with `pc_load` high and causes no register write. The final pointer is base+4·(accesses).
- R4: Push with the extra bit first stores the link register (read index 14) at base−4. It then stores set bits from bit 7 down to bit 0, each at the next lower word address. The final pointer is base−4·(accesses).
- R5: Every set bitmap bit causes exactly one access and a clear bit causes none. Store data is the register-file read data for that slot's index. A load writes `mem_rdata` to that index.
- R6: An empty bitmap with no extra slot produces `done` in the cycle after `start`, with no access and `base_wr` low.
- R7: While `mem_ready` is low, the pending request, address, direction and register index stay unchanged.
- R8: `done` and `base_wr` are single-cycle pulses one cycle after the last accepted access. `base_out` carries the final pointer. `base_wr_idx` is `instr[10:8]` for block transfers and 13 for stack transfers.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled when idle |
| instr | input | 16 | Multiple-transfer instruction word |
| base_in | input | 32 | Current value of base or stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| base_wr | output | 1 | Write final pointer back |
| base_wr_idx | output | 4 | Register receiving final pointer |
| base_out | output | 32 | Final pointer value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Access accepted this cycle |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| pc_load | output | 1 | Load program counter |
| pc_value | output | 32 | New program counter value |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight listed registers, a 4-byte step, link register 14 and stack pointer 13. With these values every bitmap pattern from empty to full can be reached, including the lone link-register push and the lone program-counter pop, where the extra slot is the only access. A combinational memory with always-ready, patterned and held-off ready modes puts both back-to-back accesses and long stalls within reach. The held-off mode also provides a window in which a second start can arrive while the first sequence is waiting.

// File: rtl/regmulti_seq.sv
module regmulti_seq #(
  parameter int DATA_W     = 32,
  parameter int NREGS      = 8,
  parameter int WORD_BYTES = 4,
  parameter int RIDX_W     = 4,
  parameter int LR_IDX     = 14,
  parameter int SP_IDX     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       instr,
  input  logic [DATA_W-1:0] base_in,
  output logic              busy,
  output logic              done,
  output logic              base_wr,
  output logic [RIDX_W-1:0] base_wr_idx,
  output logic [DATA_W-1:0] base_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [RIDX_W-1:0] rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_value
);
  localparam int SLOT_W = $clog2(NREGS);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} state_t;

  state_t            st;
  logic              load_q, push_q, xtra_q, moved_q;
  logic [NREGS-1:0]  pend_q;
  logic [DATA_W-1:0] ptr_q;
  logic [RIDX_W-1:0] bidx_q;

  function automatic logic [SLOT_W-1:0] low_slot(input logic [NREGS-1:0] m);
    low_slot = '0;
    for (int i = NREGS - 1; i >= 0; i--)
      if (m[i]) low_slot = SLOT_W'(i);
  endfunction

  function automatic logic [SLOT_W-1:0] high_slot(input logic [NREGS-1:0] m);
    high_slot = '0;
    for (int i = 0; i < NREGS; i++)
      if (m[i]) high_slot = SLOT_W'(i);
  endfunction

  logic is_block, is_stack, accept, dec_push, dec_extra, dec_empty;
  logic [NREGS-1:0] dec_list;
  assign is_block  = instr[15:12] == 4'hC;
  assign is_stack  = instr[15:12] == 4'hB && instr[10:9] == 2'b10;
  assign accept    = start && st == S_IDLE && (is_block || is_stack);
  assign dec_list  = instr[NREGS-1:0];
  assign dec_push  = is_stack && !instr[11];
  assign dec_extra = is_stack && instr[8];
  assign dec_empty = dec_list == '0 && !dec_extra;

  logic any_pend, lr_slot, pc_slot, xfer, last, nxt_xtra;
  logic [SLOT_W-1:0] cur_slot;
  logic [NREGS-1:0]  slot_bit, nxt_pend;
  logic [RIDX_W-1:0] cur_idx;

  assign any_pend = |pend_q;
  assign lr_slot  = push_q && xtra_q;
  assign pc_slot  = !push_q && xtra_q && !any_pend;
  assign cur_slot = push_q ? high_slot(pend_q) : low_slot(pend_q);
  assign slot_bit = NREGS'(1) << cur_slot;
  assign cur_idx  = lr_slot ? RIDX_W'(LR_IDX) : RIDX_W'(cur_slot);
  assign nxt_pend = (lr_slot || pc_slot) ? pend_q : (pend_q & ~slot_bit);
  assign nxt_xtra = (lr_slot || pc_slot) ? 1'b0 : xtra_q;
  assign last     = nxt_pend == '0 && !nxt_xtra;

  assign busy       = st != S_IDLE;
  assign mem_req    = st == S_XFER;
  assign xfer       = mem_req && mem_ready;
  assign mem_we     = !load_q;
  assign mem_addr   = push_q ? ptr_q - STEP : ptr_q;
  assign rf_rd_idx  = cur_idx;
  assign mem_wdata  = rf_rd_data;
  assign rf_we      = xfer && load_q && !pc_slot;
  assign rf_wr_idx  = cur_idx;
  assign rf_wr_data = mem_rdata;
  assign pc_load    = xfer && pc_slot;
  assign pc_value   = mem_rdata;
  assign done       = st == S_FIN;
  assign base_wr    = done && moved_q;
  assign base_out   = ptr_q;
  assign base_wr_idx = bidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      load_q  <= 1'b0;
      push_q  <= 1'b0;
      xtra_q  <= 1'b0;
      moved_q <= 1'b0;
      pend_q  <= '0;
      ptr_q   <= '0;
      bidx_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          load_q  <= instr[11];
          push_q  <= dec_push;
          xtra_q  <= dec_extra;
          pend_q  <= dec_list;
          ptr_q   <= base_in;
          bidx_q  <= is_block ? RIDX_W'(instr[10:8]) : RIDX_W'(SP_IDX);
          moved_q <= !dec_empty;
          st      <= dec_empty ? S_FIN : S_XFER;
        end
        S_XFER: if (xfer) begin
          ptr_q  <= push_q ? ptr_q - STEP : ptr_q + STEP;
          pend_q <= nxt_pend;
          xtra_q <= nxt_xtra;
          if (last) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(rf_rd_idx));

  // R2
  ascend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !push_q && !last |=> mem_req && mem_addr == $past(mem_addr) + STEP);

  // R4
  descend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && push_q && !last |=> mem_req && mem_addr == $past(mem_addr) - STEP);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && last |=> done && base_wr);

  // R6
  empty_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_empty |=> done && !base_wr && !mem_req);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(load_q) && $stable(push_q) && $stable(bidx_q));

  // R3
  pc_only_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> load_q && !push_q && !rf_we);
endmodule

// File: tb/regmulti_seq_test.sv
module regmulti_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] base_in = '0;
  logic        busy, done, base_wr, mem_req, mem_we, mem_ready, rf_we, pc_load;
  logic [3:0]  base_wr_idx, rf_rd_idx, rf_wr_idx;
  logic [31:0] base_out, mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, pc_value;

  logic [31:0] rf_m  [16];
  logic [31:0] mem_m [64];
  int          ready_mode = 0;
  logic [1:0]  patt = '0;

  assign rf_rd_data = rf_m[rf_rd_idx];
  assign mem_rdata  = mem_m[mem_addr[7:2]];
  assign mem_ready  = ready_mode == 0 ? 1'b1 : ready_mode == 2 ? 1'b0 : (patt != 2'd0);

  always #5 clk = ~clk;
  always @(negedge clk) patt <= patt + 2'd1;

  regmulti_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_in(base_in),
    .busy(busy), .done(done), .base_wr(base_wr), .base_wr_idx(base_wr_idx), .base_out(base_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .pc_load(pc_load), .pc_value(pc_value)
  );

  logic [31:0] log_addr [256];
  logic [31:0] log_data [256];
  logic        log_we   [256];
  int          log_idx  [256];
  int          log_n = 0;

  always begin
    @(negedge clk);
    #4;
    if (mem_req && mem_ready && log_n < 256) begin
      log_addr[log_n] = mem_addr;
      log_we[log_n]   = mem_we;
      log_idx[log_n]  = mem_we ? int'(rf_rd_idx) : (pc_load ? 15 : (rf_we ? int'(rf_wr_idx) : -1));
      log_data[log_n] = mem_we ? mem_wdata : (pc_load ? pc_value : rf_wr_data);
      log_n = log_n + 1;
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_idx(input logic [15:0] ins, input int k);
    int lst [10];
    int n = 0;
    bit stk = ins[15:12] == 4'hB;
    bit psh = stk && !ins[11];
    bit xb  = stk && ins[8];
    if (psh) begin
      if (xb) begin lst[n] = 14; n++; end
      for (int i = 7; i >= 0; i--) if (ins[i]) begin lst[n] = i; n++; end
    end else begin
      for (int i = 0; i < 8; i++) if (ins[i]) begin lst[n] = i; n++; end
      if (xb) begin lst[n] = 15; n++; end
    end
    return (k < n) ? lst[k] : -1;
  endfunction

  function automatic int exp_count(input logic [15:0] ins);
    int n = 0;
    for (int k = 0; k < 10; k++) if (exp_idx(ins, k) >= 0) n++;
    return n;
  endfunction

  task automatic run_vec(input logic [15:0] ins, input logic [31:0] base, input int rmode);
    int s0, n, e;
    bit seen, stk, psh;
    logic [31:0] fin, ea, ed;
    string tag;
    stk = ins[15:12] == 4'hB;
    psh = stk && !ins[11];
    tag = !stk ? "R2" : (psh ? "R4" : "R3");
    n   = exp_count(ins);
    fin = psh ? base - 32'(4 * n) : base + 32'(4 * n);
    ready_mode = rmode;
    s0 = log_n;
    start = 1'b1; instr = ins; base_in = base;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, "R8", "done reached", 32'(seen), 32'd1);
    chk(base_wr == (n != 0), "R8", "base_wr", 32'(base_wr), 32'(n != 0));
    if (n != 0) chk(base_out == fin, tag, "final pointer", base_out, fin);
    chk(base_wr_idx == (stk ? 4'd13 : {1'b0, ins[10:8]}), "R8", "pointer index",
        32'(base_wr_idx), stk ? 32'd13 : 32'(ins[10:8]));
    chk(log_n - s0 == n, "R5", "access count", 32'(log_n - s0), 32'(n));
    for (int k = 0; k < n && s0 + k < log_n; k++) begin
      e  = exp_idx(ins, k);
      ea = psh ? base - 32'(4 * (k + 1)) : base + 32'(4 * k);
      chk(log_addr[s0 + k] == ea, tag, "address", log_addr[s0 + k], ea);
      chk(log_idx[s0 + k] == e, tag, "slot order", 32'(log_idx[s0 + k]), 32'(e));
      chk(log_we[s0 + k] == !ins[11], "R1", "direction", 32'(log_we[s0 + k]), 32'(!ins[11]));
      ed = log_we[s0 + k] ? rf_m[e[3:0]] : mem_m[ea[7:2]];
      chk(log_data[s0 + k] == ed, "R5", "data routing", log_data[s0 + k], ed);
    end
    @(negedge clk);
    chk(!busy && !done, "R8", "idle after done", 32'({busy, done}), 32'd0);
    ready_mode = 0;
  endtask

  localparam int NV = 11;
  localparam logic [49:0] VEC [NV] = '{
    {16'hC925, 32'h0000_0040, 2'd0},
    {16'hC681, 32'h0000_0020, 2'd1},
    {16'hBC0B, 32'h0000_0080, 2'd0},
    {16'hBD11, 32'h0000_0060, 2'd1},
    {16'hB490, 32'h0000_00C0, 2'd0},
    {16'hB503, 32'h0000_00F0, 2'd1},
    {16'hC0FF, 32'h0000_0000, 2'd1},
    {16'hB500, 32'h0000_0100, 2'd0},
    {16'hBD00, 32'h0000_0010, 2'd1},
    {16'hCFFF, 32'h0000_0040, 2'd1},
    {16'hB4FF, 32'h0000_0080, 2'd0}
  };

  initial begin
    #1_000_000;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    int s0;
    for (int i = 0; i < 16; i++) rf_m[i] = 32'hA500_0000 | 32'(i * 32'h111);
    for (int i = 0; i < 64; i++) mem_m[i] = 32'h3C00_0000 + 32'(i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !mem_req, "R10", "reset outputs", 32'({busy, done, mem_req}), 32'd0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][49:34], VEC[v][33:2], int'(VEC[v][1:0]));

    // R6 empty list: done next cycle, no access, no pointer write
    s0 = log_n;
    start = 1'b1; instr = 16'hC100; base_in = 32'h44;
    @(negedge clk);
    start = 1'b0;
    chk(done && !base_wr, "R6", "empty block done", 32'({done, base_wr}), 32'b10);
    chk(log_n == s0, "R6", "empty no access", 32'(log_n - s0), 32'd0);
    @(negedge clk);
    start = 1'b1; instr = 16'hBC00;
    @(negedge clk);
    start = 1'b0;
    chk(done && !base_wr && log_n == s0, "R6", "empty pop", 32'({done, base_wr}), 32'b10);
    @(negedge clk);

    // R1 unrecognised words
    start = 1'b1; instr = 16'hB000;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !mem_req, "R1", "bad stack subop idle", 32'({busy, mem_req}), 32'd0);
    start = 1'b1; instr = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !mem_req, "R1", "foreign word idle", 32'({busy, mem_req}), 32'd0);
    @(negedge clk);
    chk(!done && log_n == s0, "R1", "no done", 32'(done), 32'd0);

    // R7 stall and R9 start while busy
    ready_mode = 2;
    start = 1'b1; instr = 16'hC203; base_in = 32'h20;
    @(negedge clk);
    start = 1'b0;
    chk(busy && mem_req && mem_addr == 32'h20, "R7", "request raised", mem_addr, 32'h20);
    start = 1'b1; instr = 16'hC4F0; base_in = 32'h80;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_req && mem_addr == 32'h20 && mem_we, "R7", "held under stall", mem_addr, 32'h20);
    chk(rf_rd_idx == 4'd0, "R7", "slot held", 32'(rf_rd_idx), 32'd0);
    ready_mode = 0;
    for (int i = 0; i < 20; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done && base_out == 32'h28, "R9", "first op kept pointer", base_out, 32'h28);
    chk(base_wr_idx == 4'd2, "R9", "first op kept base reg", 32'(base_wr_idx), 32'd2);
    chk(log_n - s0 == 2, "R9", "first op kept list", 32'(log_n - s0), 32'd2);
    @(negedge clk);
    @(negedge clk);
    chk(!busy && log_n - s0 == 2, "R9", "late start not replayed", 32'(busy), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule